// File: doc/BRIEF.md
# Free-Running Timer With Coherent Two-Step Read

This block holds a 12-bit counter that advances by one on every 1 MHz enable tick and wraps from its top value back to zero. The counter therefore spans about 4 ms. A CPU reads it through an 8-bit read-only port in two steps. The first step reads the low byte. The second step reads the upper nibble.

The two reads can be far apart in time. To keep them consistent, the low-byte read copies the upper four counter bits into a shadow register. It takes those bits from the same sample that supplies the low byte. The later high read returns the shadow register, not the live count, so the two halves always form one 12-bit value.

The block also drives two periodic interrupt strobes, each one clock wide. One fires every 128 ticks (128 µs). The other fires every 1024 ticks (1.024 ms).

Top module: `lat_timer`

## Requirements
- R1: While `rst_n` is low, the counter and the shadow register clear to zero. `rd_data`, `irq_fast` and `irq_slow` are also zero at the first clock after reset is released.
- R2: At each rising edge where `tick` is high, the counter increases by one. It holds when `tick` is low. From 0xFFF it wraps to 0x000.
- R3: `irq_fast` is high for exactly one clock cycle. That cycle directly follows the ticked edge that turns counter bits 6:0 from all ones to zero, so the pulse comes once every 128 ticks.
- R4: `irq_slow` behaves the same way for counter bits 9:0, once every 1024 ticks. Whenever it is high, `irq_fast` is high too.
- R5: A cycle with `rd_lo` high puts counter bits 7:0 on `rd_data` in the next cycle. The value is the one held before any increment at that same edge.
- R6: A `rd_lo` cycle loads the shadow register with counter bits 11:8, taken from the same sample as R5.
- R7: A cycle with `rd_hi` high (and `rd_lo` low) puts {4'b0000, shadow} on `rd_data` in the next cycle. Neither ticks nor high reads change the shadow register.
- R8: When `rd_lo` and `rd_hi` are both high in the same cycle, the low read takes effect: the low byte is returned and the shadow is loaded.
- R9: In a cycle with neither strobe high, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 MHz count enable, one clock wide |
| rd_lo | input | 1 | Read strobe for the low-byte address |
| rd_hi | input | 1 | Read strobe for the high-nibble address |
| rd_data | output | 8 | Registered read data |
| irq_fast | output | 1 | 128-tick interrupt strobe |
| irq_slow | output | 1 | 1024-tick interrupt strobe |

## Verification
The bound checker watches these rules on every cycle:
- the counter's step-or-hold rule;
- that each interrupt strobe lines up with a just-ticked zero in the counter's low bits and lasts only one cycle;
- that the slow strobe never appears without the fast one;
- that every low read returns the pre-increment low byte and loads the shadow from the same sample;
- that a high read clears the reserved upper bits.

The bench scenarios cover what needs a long history:
- a high read many ticks after its low read, across a carry into bit 8, still returning the old nibble;
- the 128- and 1024-tick interrupt spacing;
- the full 4096-tick wrap;
- the low-read priority when both strobes arrive together.

// File: rtl/lat_timer.sv
module lat_timer #(
  parameter int CNT_W     = 12,
  parameter int LO_W      = 8,
  parameter int FAST_BITS = 7,
  parameter int SLOW_BITS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rd_lo,
  input  logic            rd_hi,
  output logic [LO_W-1:0] rd_data,
  output logic            irq_fast,
  output logic            irq_slow
);
  localparam int HI_W  = CNT_W - LO_W;
  localparam int PAD_W = LO_W - HI_W;

  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  shadow;
  logic             fast_wrap, slow_wrap;

  assign fast_wrap = tick && (&cnt[FAST_BITS-1:0]);
  assign slow_wrap = tick && (&cnt[SLOW_BITS-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      irq_fast <= 1'b0;
      irq_slow <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      irq_fast <= fast_wrap;
      irq_slow <= slow_wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= '0;
      rd_data <= '0;
    end else if (rd_lo) begin
      shadow  <= cnt[CNT_W-1:LO_W];
      rd_data <= cnt[LO_W-1:0];
    end else if (rd_hi) begin
      rd_data <= {{PAD_W{1'b0}}, shadow};
    end
  end
endmodule

// File: rtl/lat_timer_chk.sv
module lat_timer_chk #(
  parameter int CNT_W     = 12,
  parameter int LO_W      = 8,
  parameter int FAST_BITS = 7,
  parameter int SLOW_BITS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             rd_lo,
  input logic             rd_hi,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-LO_W-1:0] shadow,
  input logic [LO_W-1:0]  rd_data,
  input logic             irq_fast,
  input logic             irq_slow
);
  localparam int HI_W = CNT_W - LO_W;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CNT_W'($past(cnt) + 1'b1));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  assert_fast_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_fast) |-> (cnt[FAST_BITS-1:0] == '0) && $past(tick));
  assert_fast_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |=> !irq_fast);
  assert_slow_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |-> (cnt[SLOW_BITS-1:0] == '0) && irq_fast);
  assert_lo_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> rd_data == $past(cnt[LO_W-1:0]));
  assert_shadow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> shadow == $past(cnt[CNT_W-1:LO_W]));
  assert_shadow_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(shadow));
  assert_hi_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo) |=> rd_data[LO_W-1:HI_W] == '0);
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hi && !rd_lo) |=> $stable(rd_data));
endmodule

bind lat_timer lat_timer_chk #(
  .CNT_W(CNT_W), .LO_W(LO_W), .FAST_BITS(FAST_BITS), .SLOW_BITS(SLOW_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .cnt(cnt), .shadow(shadow), .rd_data(rd_data),
  .irq_fast(irq_fast), .irq_slow(irq_slow)
);

// File: tb/lat_timer_bench.sv
module lat_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic [7:0] rd_data;
  logic       irq_fast, irq_slow;

  int tests = 0, fails = 0;
  logic [11:0] mdl = '0;
  logic [3:0]  shd = '0;
  logic [7:0]  dat = '0;

  always #4 clk = ~clk;

  lat_timer u_lat_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rd_data(rd_data), .irq_fast(irq_fast), .irq_slow(irq_slow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, predict, check at next negedge
  task automatic cyc(logic t, logic l, logic h);
    logic ef, es;
    tick = t; rd_lo = l; rd_hi = h;
    ef = t && (mdl[6:0] == 7'h7F);
    es = t && (mdl[9:0] == 10'h3FF);
    if (l) begin dat = mdl[7:0]; shd = mdl[11:8]; end
    else if (h) dat = {4'h0, shd};
    if (t) mdl = mdl + 1'b1;
    @(negedge clk);
    chk("R3", irq_fast, ef);
    chk("R4", irq_slow, es);
    if (l && h)      chk("R8", rd_data, dat);
    else if (l)      chk("R5", rd_data, dat);
    else if (h)      chk("R7", rd_data, dat);
    else             chk("R9", rd_data, dat);
    tick = 0; rd_lo = 0; rd_hi = 0;
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mdl = '0; shd = '0; dat = '0;
    @(negedge clk);
    chk("R1", rd_data, 8'h00);
    chk("R1", irq_fast, 1'b0);
    chk("R1", irq_slow, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R1", rd_data, 8'h00);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R1", rd_data, 8'h00);
  endtask

  task automatic t_count;
    run_ticks(5);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R2", rd_data, 8'h05);
    cyc(1'b1, 1'b1, 1'b0);
    chk("R5", rd_data, 8'h05);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R2", rd_data, 8'h06);
  endtask

  task automatic t_coherent;
    run_ticks(int'(12'h0FF - mdl));
    cyc(1'b1, 1'b1, 1'b0);
    chk("R5", rd_data, 8'hFF);
    run_ticks(300);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R6", rd_data, 8'h00);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R6", rd_data, {4'h0, mdl[11:8]});
    chk("R7", rd_data[7:4], 4'h0);
  endtask

  task automatic t_irq;
    int nf = 0, ns = 0;
    for (int i = 0; i < 2100; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      nf += irq_fast; ns += irq_slow;
    end
    chk("R3", nf, 16);
    chk("R4", ns, 2);
  endtask

  task automatic t_wrap;
    run_ticks(int'(12'hFFF - mdl));
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R2", rd_data, 8'h0F);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R2", rd_data, 8'h00);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R8", rd_data, 8'h00);
  endtask

  task automatic t_both;
    run_ticks(600);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R8", rd_data, mdl[7:0]);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R8", rd_data, {4'h0, mdl[11:8]});
    repeat (3) cyc(1'b1, 1'b0, 1'b0);
    chk("R9", rd_data, {4'h0, shd});
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_coherent();
    t_irq();
    t_wrap();
    t_both();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule